// File: doc/BRIEF.md
# Event-Triggered Key Matrix Scanner

This block reads a keypad wired as a grid of drive lines and sense inputs: six drive lines and five sense inputs, up to thirty keys. Each sense input has a pull-down, so a released key reads 0. While no key is down, the block sits in an idle state. In that state it drives every enabled drive line high and watches the OR of the sense inputs. Any sense input going high starts a scan. The scan drives one line at a time and holds each line for `DWELL` clock enables. It samples the five sense bits on the last enable of that window.

A full pass produces a 30-bit image. The image is published on `key_img` only when two passes in a row agree and are non-zero, and publishing a changed image raises `key_rdy` for one clock. A pass that reads all zeros sends the block back to idle and clears the published image. The two lowest drive lines can be handed to another function through `seg_mask`. Those lines are then held low, skipped, and their ten key bits read as zero. Reset clears the image and keeps the block idle. In sleep, a key press starts a scan without waiting for a clock enable.

States and transitions:
- IDLE -> SCAN, on a wake.
- SCAN -> EVAL, after the last line is sampled.
- EVAL -> SCAN, when the pass was non-zero.
- EVAL -> IDLE, when the pass was all zeros.

Top module: `kms_scanner`

## Requirements
- R1: While reset is asserted and just after it is released, `key_img` is 0, `key_rdy` is 0 and the block stays idle with all enabled drive lines high, even if keys are pressed.
- R2: In IDLE every enabled line of `scan_o` is high. The block leaves IDLE only in a cycle where some sense input is high and either `scan_en` or `sleep` is high.
- R3: In SCAN exactly one line of `scan_o` is high. Lines are visited in rising index order from the lowest enabled line. Each line is held for `DWELL` cycles with `scan_en` high, and the sense bits are captured on the last of them. During the one-cycle EVAL state `scan_o` is all low.
- R4: The key on drive line L and sense input S maps to bit L*5+S of `key_img`.
- R5: With `seg_mask` high, lines 0 and 1 are driven low in every state and are skipped by the scan. Keys on them neither wake the block nor appear in `key_img`, whose bits 0 to 9 stay 0.
- R6: `key_img` is updated in the cycle after an EVAL whose pass is non-zero, equals the previous pass, and differs from the published image. `key_rdy` is high for exactly that one cycle.
- R7: A pass that repeats the image already published produces no `key_rdy` pulse and leaves `key_img` unchanged.
- R8: An all-zero pass returns the block to IDLE, clears `key_img` and raises no `key_rdy`.
- R9: With `sleep` high, a sense input going high moves IDLE to SCAN even while `scan_en` is low.
- R10: While `scan_en` is low during SCAN, `scan_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Clock enable that paces the scan |
| sleep | input | 1 | Sleep request; a press wakes the scanner directly |
| seg_mask | input | 1 | Removes drive lines 0 and 1 from the matrix |
| sense_i | input | 5 | Sense inputs, high when a key on a driven line is down |
| scan_o | output | 6 | Drive lines |
| key_img | output | 30 | Published stable key image |
| key_rdy | output | 1 | One-cycle pulse when a new image is published |

## Verification
The bench runs a behavioural reference model of the scanner and compares every clock. The stimulus covers several patterns:
- A single key on a middle line checks bit placement.
- A second key added to a held one checks that a new image is reported while a repeated one is not.
- Releasing the keys checks the return to idle.
- A press on a masked line, alone and together with a key on an unmasked line, checks that masked keys neither wake the block nor show up in the image.
- Slow and frozen clock enables check the dwell timing and the hold of the drive lines.
- A press in sleep with no clock enable checks the wake path, and the same press without sleep checks that the block stays idle.

// File: rtl/kms_pkg.sv
package kms_pkg;
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_SCAN = 2'd1,
        KS_EVAL = 2'd2
    } kscan_state_e;
endpackage

// File: rtl/kms_line_seq.sv
module kms_line_seq #(
    parameter int LINES = 6,
    parameter int DWELL = 4,
    localparam int IW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [IW-1:0] first_idx,
    input  logic          advance,
    output logic [IW-1:0] idx,
    output logic          sample,
    output logic          last_line
);
    logic [CW-1:0] dwell_q;

    assign sample    = advance && (dwell_q == CW'(DWELL - 1));
    assign last_line = (idx == IW'(LINES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            dwell_q <= '0;
        end else if (restart) begin
            idx     <= first_idx;
            dwell_q <= '0;
        end else if (advance) begin
            if (dwell_q == CW'(DWELL - 1)) begin
                dwell_q <= '0;
                if (!last_line) idx <= idx + 1'b1;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end
    end

    // R3: the line index only moves when a sample is taken
    p_idx_moves_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !sample) |=> $stable(idx));
endmodule

// File: rtl/kms_key_image.sv
module kms_key_image #(
    parameter int LINES = 6,
    parameter int SENSE = 5,
    localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int KEYS = LINES * SENSE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [IW-1:0]    idx,
    input  logic [SENSE-1:0] sense,
    input  logic             eval,
    output logic [KEYS-1:0]  key_img,
    output logic             key_rdy,
    output logic             cur_zero
);
    logic [SENSE-1:0] row_q [LINES];
    logic [KEYS-1:0]  cur;
    logic [KEYS-1:0]  prev_q;

    for (genvar i = 0; i < LINES; i++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             row_q[i] <= '0;
            else if (clear)                         row_q[i] <= '0;
            else if (sample && idx == IW'(i))       row_q[i] <= sense;
        end
        assign cur[i*SENSE +: SENSE] = row_q[i];
    end

    assign cur_zero = (cur == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            key_img <= '0;
            key_rdy <= 1'b0;
        end else begin
            key_rdy <= 1'b0;
            if (eval) begin
                if (cur_zero) begin
                    prev_q  <= '0;
                    key_img <= '0;
                end else begin
                    if (cur == prev_q && cur != key_img) begin
                        key_img <= cur;
                        key_rdy <= 1'b1;
                    end
                    prev_q <= cur;
                end
            end
        end
    end

    // R6: the ready pulse lasts one cycle
    p_rdy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_rdy |=> !key_rdy);
    // R6: a new non-zero image is always announced
    p_img_announced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_img != $past(key_img) && key_img != '0) |-> key_rdy);
    // R8: an empty pass clears the image silently
    p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && cur_zero) |=> (key_img == '0 && !key_rdy));
endmodule

// File: rtl/kms_scanner.sv
module kms_scanner
    import kms_pkg::*;
#(
    parameter int LINES     = 6,
    parameter int SENSE     = 5,
    parameter int DWELL     = 4,
    parameter int SEG_LINES = 2,
    localparam int KEYS = LINES * SENSE,
    localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             sleep,
    input  logic             seg_mask,
    input  logic [SENSE-1:0] sense_i,
    output logic [LINES-1:0] scan_o,
    output logic [KEYS-1:0]  key_img,
    output logic             key_rdy
);
    kscan_state_e state_q, state_d;

    logic          wake, restart, advance, eval;
    logic          sample, last_line, cur_zero;
    logic [IW-1:0] idx, first_idx;
    logic [LINES-1:0] line_en, line_hot;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i < SEG_LINES) begin : g_shared
            assign line_en[i] = !seg_mask;
        end else begin : g_fixed
            assign line_en[i] = 1'b1;
        end
        assign line_hot[i] = (idx == IW'(i));
    end

    assign first_idx = seg_mask ? IW'(SEG_LINES) : '0;
    assign wake      = (|sense_i) && (scan_en || sleep);
    assign advance   = (state_q == KS_SCAN) && scan_en;
    assign eval      = (state_q == KS_EVAL);
    assign restart   = ((state_q == KS_IDLE) && wake) || (eval && !cur_zero);

    kms_line_seq #(.LINES(LINES), .DWELL(DWELL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .first_idx (first_idx),
        .advance   (advance),
        .idx       (idx),
        .sample    (sample),
        .last_line (last_line)
    );

    kms_key_image #(.LINES(LINES), .SENSE(SENSE)) u_img (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .sample   (sample),
        .idx      (idx),
        .sense    (sense_i),
        .eval     (eval),
        .key_img  (key_img),
        .key_rdy  (key_rdy),
        .cur_zero (cur_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE: if (wake) state_d = KS_SCAN;
            KS_SCAN: if (sample && last_line) state_d = KS_EVAL;
            KS_EVAL: state_d = cur_zero ? KS_IDLE : KS_SCAN;
            default: state_d = KS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            KS_IDLE: scan_o = line_en;
            KS_SCAN: scan_o = line_hot & line_en;
            KS_EVAL: scan_o = '0;
            default: scan_o = '0;
        endcase
    end

    // R3: one drive line during a scan
    p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_SCAN) |-> $countones(scan_o) == 1);
    // R10: lines hold while the enable is low
    p_hold_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_SCAN && !scan_en) |=> $stable(scan_o));
    // R2: no exit from idle without a pressed key
    p_idle_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_IDLE && !(|sense_i)) |=> state_q == KS_IDLE);
endmodule

// File: tb/kms_scanner_tb_top.sv
module kms_scanner_tb_top;
    localparam int LINES = 6;
    localparam int SENSE = 5;
    localparam int DWELL = 4;
    localparam int KEYS  = LINES * SENSE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic sleep = 1'b0;
    logic seg_mask = 1'b0;
    logic [SENSE-1:0] sense_i;
    logic [LINES-1:0] scan_o;
    logic [KEYS-1:0]  key_img;
    logic             key_rdy;

    logic [KEYS-1:0] keys = '0;
    int en_div = 1;
    bit en_off = 1'b0;
    int tick_cnt = 0;
    int checks = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kms_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .sleep(sleep),
        .seg_mask(seg_mask), .sense_i(sense_i), .scan_o(scan_o),
        .key_img(key_img), .key_rdy(key_rdy)
    );

    // key matrix: a sense input is high when a pressed key sits on a driven line
    always_comb begin
        sense_i = '0;
        for (int l = 0; l < LINES; l++)
            for (int s = 0; s < SENSE; s++)
                if (scan_o[l] && keys[l*SENSE+s]) sense_i[s] = 1'b1;
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    int m_state = 0;
    int m_idx = 0;
    int m_cnt = 0;
    logic [KEYS-1:0] m_cur = '0, m_prev = '0, m_img = '0;
    logic m_rdy = 1'b0;

    function automatic logic [LINES-1:0] m_lines();
        logic [LINES-1:0] v;
        if (m_state == 0) begin
            v = '1;
            if (seg_mask) v[1:0] = 2'b00;
        end else if (m_state == 1) begin
            v = '0;
            v[m_idx] = 1'b1;
        end else v = '0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_cnt = 0;
            m_cur = '0; m_prev = '0; m_img = '0; m_rdy = 1'b0;
        end else begin
            m_rdy = 1'b0;
            if (m_state == 0) begin
                if ((|sense_i) && (scan_en || sleep)) begin
                    m_state = 1; m_idx = seg_mask ? 2 : 0; m_cnt = 0; m_cur = '0;
                end
            end else if (m_state == 1) begin
                if (scan_en) begin
                    if (m_cnt == DWELL - 1) begin
                        m_cur[m_idx*SENSE +: SENSE] = sense_i;
                        m_cnt = 0;
                        if (m_idx == LINES - 1) m_state = 2;
                        else m_idx++;
                    end else m_cnt++;
                end
            end else begin
                if (m_cur == '0) begin
                    m_prev = '0; m_img = '0; m_state = 0;
                end else begin
                    if (m_cur == m_prev && m_cur != m_img) begin
                        m_img = m_cur; m_rdy = 1'b1;
                    end
                    m_prev = m_cur;
                    m_state = 1; m_idx = seg_mask ? 2 : 0; m_cnt = 0; m_cur = '0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(64'(scan_o), 64'(m_lines()), "R3 drive lines vs model");
            chk(64'(key_img), 64'(m_img), "R6 key image vs model");
            chk(64'(key_rdy), 64'(m_rdy), "R6 ready pulse vs model");
            if (key_rdy) pulses++;
        end
    end

    initial begin
        forever begin
            @(negedge clk); #1;
            tick_cnt++;
            scan_en = !en_off && (tick_cnt % en_div == 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [LINES-1:0] held;
        // R1: keys pressed during reset must not start a scan
        keys = KEYS'(1) << 13;
        wait_cyc(4);
        chk(64'(scan_o), 64'h3F, "R1 lines idle in reset");
        chk(64'(key_img), 64'h0, "R1 image clear in reset");
        keys = '0;
        wait_cyc(1);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(64'(scan_o), 64'h3F, "R1 idle after reset");
        chk(64'(key_rdy), 64'h0, "R1 no ready after reset");

        // R4, R6: single key on line 2, sense 3
        keys = KEYS'(1) << 13;
        wait_cyc(120);
        chk(64'(key_img), 64'(KEYS'(1) << 13), "R4 bit position");
        chk(64'(pulses), 64'd1, "R6 one pulse for new image");
        // R7: holding the same keys gives no new pulse
        wait_cyc(100);
        chk(64'(pulses), 64'd1, "R7 repeat image silent");
        keys = (KEYS'(1) << 13) | (KEYS'(1) << 29);
        wait_cyc(120);
        chk(64'(key_img), 64'((KEYS'(1) << 13) | (KEYS'(1) << 29)), "R6 updated image");
        chk(64'(pulses), 64'd2, "R6 second pulse");
        // R8: release
        keys = '0;
        wait_cyc(60);
        chk(64'(key_img), 64'h0, "R8 image cleared");
        chk(64'(scan_o), 64'h3F, "R8 back to idle");
        chk(64'(pulses), 64'd2, "R8 no pulse on release");

        // R5: masked lines
        seg_mask = 1'b1;
        keys = KEYS'(1) << 2;
        wait_cyc(60);
        chk(64'(scan_o), 64'h3C, "R5 masked key does not wake");
        keys = (KEYS'(1) << 2) | (KEYS'(1) << 22);
        wait_cyc(120);
        chk(64'(key_img), 64'(KEYS'(1) << 22), "R5 masked bits zero");
        keys = '0;
        wait_cyc(60);
        seg_mask = 1'b0;

        // R10: frozen enable holds the lines
        en_div = 3;
        keys = KEYS'(1) << 7;
        wait_cyc(8);
        en_off = 1'b1;
        wait_cyc(2);
        held = scan_o;
        wait_cyc(20);
        chk(64'(scan_o), 64'(held), "R10 lines held");
        chk(64'($countones(scan_o)), 64'd1, "R3 one line while frozen");
        en_off = 1'b0;
        wait_cyc(200);
        chk(64'(key_img), 64'(KEYS'(1) << 7), "R3 slow enable image");
        keys = '0;
        wait_cyc(150);
        en_div = 1;

        // R2: no enable, no sleep, stays idle
        en_off = 1'b1;
        keys = KEYS'(1) << 25;
        wait_cyc(10);
        chk(64'(scan_o), 64'h3F, "R2 idle without enable");
        // R9: sleep wakes without enable
        sleep = 1'b1;
        wait_cyc(3);
        chk(64'(scan_o), 64'h01, "R9 sleep wake starts scan");
        en_off = 1'b0;
        wait_cyc(120);
        chk(64'(key_img), 64'(KEYS'(1) << 25), "R9 image after wake");
        keys = '0;
        wait_cyc(60);
        chk(64'(scan_o), 64'h3F, "R8 idle after sleep scan");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule